// File: doc/BRIEF.md
# Repairable Return Address Stack

This block predicts return targets for a pipelined fetch unit. Each predicted call pushes its return address, which is the call address plus the instruction size. Each predicted return reads the current top entry as its target and then pops it. The storage is a circular buffer of fixed depth. When more calls arrive than the buffer can hold, the oldest entries are overwritten silently.

Fetch may pop entries on a wrong path. To undo that, the front end saves a checkpoint when it predicts a return: the top index and the value read there. If the return turns out to be on a wrong path, the repair port writes that checkpoint back. The pointer returns to the saved index and the saved address is written into that slot. The empty flag tells fetch that a return must not be predicted taken.

Top module: `ras_top`

## Requirements
- R1: After reset, `empty_o` is 1, `top_idx_o` is 15 and `top_addr_o` is 0.
- R2: A push (`call_i` = 1, `rep_i` = 0) takes effect at the next clock edge. After that edge, `top_addr_o` equals `call_pc_i` + 4, `top_idx_o` equals the old index + 1 modulo 16, and `empty_o` is 0. The first push after reset goes to slot 0.
- R3: A pop (`ret_i` = 1, with `call_i` = 0, `rep_i` = 0 and a non-empty stack) lowers `top_idx_o` by 1 modulo 16. Pushed addresses come back in reverse order.
- R4: The block keeps an occupancy count that saturates at 16. `empty_o` is 1 exactly when that count is 0, so popping every pushed entry raises `empty_o`.
- R5: A pop while `empty_o` is 1 changes nothing: `top_idx_o`, `top_addr_o` and `empty_o` all keep their values.
- R6: Pushes beyond 16 overwrite the oldest slot circularly. After 17 pushes, 16 pops return the 16 newest addresses, newest first, and then `empty_o` is 1.
- R7: A repair (`rep_i` = 1) sets `top_idx_o` to `rep_idx_i` and writes `rep_addr_i` into that slot, so `top_addr_o` shows it. It writes no other slot. It raises the occupancy to at least 1 and leaves any larger count unchanged.
- R8: A repair wins over a push or a pop in the same cycle. The push writes nothing and moves nothing.
- R9: When a push and a pop arrive together without a repair, the push is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Push the return address of a predicted call |
| call_pc_i | input | 32 | Address of the call instruction |
| ret_i | input | 1 | Pop the top entry of a predicted return |
| rep_i | input | 1 | Repair from a saved checkpoint |
| rep_idx_i | input | 4 | Checkpointed top index |
| rep_addr_i | input | 32 | Checkpointed entry value |
| top_addr_o | output | 32 | Current top entry (return target) |
| top_idx_o | output | 4 | Current top index |
| empty_o | output | 1 | Stack holds no entries |

## Verification
Nested calls followed by returns show that ordering is last-in-first-out and that the pointer wraps at both ends. A run of 17 calls separates a circular overwrite of the oldest slot from a saturating count. A wrong-path sequence of pops followed by a repair shows that only the checkpointed slot is rewritten and that a larger count survives. A repair from an empty stack shows the occupancy forced to one. Same-cycle push/repair and push/pop patterns, plus pops on an empty stack, pin down the priority order and which requests are ignored.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_PUSH    = 2'd1,
    OP_POP     = 2'd2,
    OP_RESTORE = 2'd3
  } ras_op_e;

  // Priority: repair, then push, then pop (only when something is held).
  function automatic ras_op_e pick_op(input logic push, input logic pop_ok,
                                      input logic repair);
    if (repair)      return OP_RESTORE;
    else if (push)   return OP_PUSH;
    else if (pop_ok) return OP_POP;
    else             return OP_IDLE;
  endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             repair_i,
  input  logic [IDX_W-1:0] repair_idx_i,
  output logic [IDX_W-1:0] top_idx_o,
  output logic             empty_o,
  output ras_op_e          op_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [IDX_W-1:0] tp_q, tp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             has_entry;

  function automatic logic [IDX_W-1:0] idx_up(input logic [IDX_W-1:0] i);
    return (i == IDX_LAST) ? '0 : i + IDX_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] idx_down(input logic [IDX_W-1:0] i);
    return (i == '0) ? IDX_LAST : i - IDX_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_up(input logic [CNT_W-1:0] c);
    return (c == CNT_FULL) ? CNT_FULL : c + CNT_ONE;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_floor1(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_ONE : c;
  endfunction

  assign has_entry = (cnt_q != '0);
  assign op_o      = pick_op(push_i, pop_i && has_entry, repair_i);

  always_comb begin
    tp_d     = tp_q;
    cnt_d    = cnt_q;
    wr_en_o  = 1'b0;
    wr_idx_o = idx_up(tp_q);
    case (op_o)
      OP_PUSH: begin
        tp_d    = idx_up(tp_q);
        cnt_d   = cnt_up(cnt_q);
        wr_en_o = 1'b1;
      end
      OP_POP: begin
        tp_d  = idx_down(tp_q);
        cnt_d = cnt_q - CNT_ONE;
      end
      OP_RESTORE: begin
        tp_d     = repair_idx_i;
        cnt_d    = cnt_floor1(cnt_q);
        wr_en_o  = 1'b1;
        wr_idx_o = repair_idx_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tp_q  <= IDX_LAST;
      cnt_q <= '0;
    end else begin
      tp_q  <= tp_d;
      cnt_q <= cnt_d;
    end
  end

  assign top_idx_o = tp_q;
  assign empty_o   = !has_entry;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);

  logic [ADDR_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/ras_top.sv
module ras_top
  import ras_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       call_i,
  input  logic [ADDR_W-1:0]          call_pc_i,
  input  logic                       ret_i,
  input  logic                       rep_i,
  input  logic [$clog2(DEPTH)-1:0]   rep_idx_i,
  input  logic [ADDR_W-1:0]          rep_addr_i,
  output logic [ADDR_W-1:0]          top_addr_o,
  output logic [$clog2(DEPTH)-1:0]   top_idx_o,
  output logic                       empty_o
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [ADDR_W-1:0] ret_addr(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(INST_BYTES);
  endfunction

  ras_op_e           op_w;
  logic              wr_en_w;
  logic [IDX_W-1:0]  wr_idx_w;
  logic [ADDR_W-1:0] wr_data_w;

  ras_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (call_i),
    .pop_i        (ret_i),
    .repair_i     (rep_i),
    .repair_idx_i (rep_idx_i),
    .top_idx_o    (top_idx_o),
    .empty_o      (empty_o),
    .op_o         (op_w),
    .wr_en_o      (wr_en_w),
    .wr_idx_o     (wr_idx_w)
  );

  assign wr_data_w = (op_w == OP_RESTORE) ? rep_addr_i : ret_addr(call_pc_i);

  ras_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_w),
    .wr_idx_i  (wr_idx_w),
    .wr_data_i (wr_data_w),
    .rd_idx_i  (top_idx_o),
    .rd_data_o (top_addr_o)
  );

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic [ADDR_W-1:0] call_pc_i,
  input logic              ret_i,
  input logic              rep_i,
  input logic [IDX_W-1:0]  rep_idx_i,
  input logic [ADDR_W-1:0] rep_addr_i,
  input logic [ADDR_W-1:0] top_addr_o,
  input logic [IDX_W-1:0]  top_idx_o,
  input logic              empty_o,
  input logic              wr_en_w,
  input logic [IDX_W-1:0]  wr_idx_w
);

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n) (call_i && !rep_i) |=> (top_addr_o == $past(call_pc_i) + ADDR_W'(4)) && !empty_o); // R2
  AST_PUSH_IDX: assert property (@(posedge clk) disable iff (!rst_n) (call_i && !rep_i) |=> (top_idx_o == IDX_W'($past(top_idx_o) + IDX_W'(1)))); // R2
  AST_POP_IDX: assert property (@(posedge clk) disable iff (!rst_n) (ret_i && !call_i && !rep_i && !empty_o) |=> (top_idx_o == IDX_W'($past(top_idx_o) - IDX_W'(1)))); // R3
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ret_i && !call_i && !rep_i && empty_o) |=> empty_o && $stable(top_idx_o) && $stable(top_addr_o)); // R5
  AST_REPAIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) rep_i |=> (top_idx_o == $past(rep_idx_i)) && (top_addr_o == $past(rep_addr_i)) && !empty_o); // R7
  AST_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) wr_en_w |=> (top_idx_o == $past(wr_idx_w))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!call_i && !ret_i && !rep_i) |=> $stable(top_idx_o) && $stable(top_addr_o) && $stable(empty_o)); // R4

endmodule

bind ras_top ras_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ras_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .call_i     (call_i),
  .call_pc_i  (call_pc_i),
  .ret_i      (ret_i),
  .rep_i      (rep_i),
  .rep_idx_i  (rep_idx_i),
  .rep_addr_i (rep_addr_i),
  .top_addr_o (top_addr_o),
  .top_idx_o  (top_idx_o),
  .empty_o    (empty_o),
  .wr_en_w    (wr_en_w),
  .wr_idx_w   (wr_idx_w)
);

// File: tb/tb_ras_top.sv
module tb_ras_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0;
  logic [31:0] call_pc_i = '0;
  logic        ret_i = 1'b0;
  logic        rep_i = 1'b0;
  logic [3:0]  rep_idx_i = '0;
  logic [31:0] rep_addr_i = '0;
  logic [31:0] top_addr_o;
  logic [3:0]  top_idx_o;
  logic        empty_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  ras_top dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
    .ret_i(ret_i), .rep_i(rep_i), .rep_idx_i(rep_idx_i), .rep_addr_i(rep_addr_i),
    .top_addr_o(top_addr_o), .top_idx_o(top_idx_o), .empty_o(empty_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [31:0] ea,
                           input logic [3:0] ei, input logic ee);
    chk(req, "top_addr", top_addr_o, ea);
    chk(req, "top_idx", {28'd0, top_idx_o}, {28'd0, ei});
    chk(req, "empty", {31'd0, empty_o}, {31'd0, ee});
  endtask

  task automatic cycle(input bit c, input logic [31:0] pc, input bit r,
                       input bit f, input logic [3:0] fi, input logic [31:0] fa);
    call_i = c; call_pc_i = pc; ret_i = r; rep_i = f; rep_idx_i = fi; rep_addr_i = fa;
    @(posedge clk);
    @(negedge clk);
    call_i = 1'b0; ret_i = 1'b0; rep_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] pc);
    cycle(1'b1, pc, 1'b0, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic pop();
    cycle(1'b0, 32'd0, 1'b1, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1", 32'd0, 4'd15, 1'b1);
  endtask

  task automatic t_lifo();
    do_reset();
    push(32'h100);
    chk_state("R2", 32'h104, 4'd0, 1'b0);
    push(32'h200);
    push(32'h300);
    chk_state("R2", 32'h304, 4'd2, 1'b0);
    pop();
    chk_state("R3", 32'h204, 4'd1, 1'b0);
    pop();
    chk_state("R3", 32'h104, 4'd0, 1'b0);
    pop();
    chk("R4", "empty after last pop", {31'd0, empty_o}, 32'd1);
    chk("R3", "index wraps down", {28'd0, top_idx_o}, 32'd15);
  endtask

  task automatic t_empty_pop();
    do_reset();
    push(32'h500);
    pop();
    chk("R4", "empty", {31'd0, empty_o}, 32'd1);
    pop();
    chk_state("R5", 32'd0, 4'd15, 1'b1);
    pop();
    chk_state("R5", 32'd0, 4'd15, 1'b1);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < 17; k++) push(32'h1000 + 32'(k) * 32'h10);
    chk_state("R6", 32'h1000 + 32'd16 * 32'h10 + 32'd4, 4'd0, 1'b0);
    for (int j = 1; j <= 15; j++) begin
      pop();
      chk("R6", "newest order", top_addr_o, 32'h1000 + 32'(16 - j) * 32'h10 + 32'd4);
    end
    chk("R6", "not empty before 16th pop", {31'd0, empty_o}, 32'd0);
    pop();
    chk("R6", "empty after 16 pops", {31'd0, empty_o}, 32'd1);
  endtask

  task automatic t_repair();
    do_reset();
    push(32'hA00); push(32'hB00); push(32'hC00); push(32'hD00);
    pop(); pop();
    chk_state("R3", 32'hB04, 4'd1, 1'b0);
    cycle(1'b0, 32'd0, 1'b0, 1'b1, 4'd3, 32'hDEAD0);
    chk_state("R7", 32'hDEAD0, 4'd3, 1'b0);
    pop();
    chk_state("R7", 32'hC04, 4'd2, 1'b0);
    pop();
    chk_state("R7", 32'hB04, 4'd1, 1'b1);
    do_reset();
    cycle(1'b0, 32'd0, 1'b0, 1'b1, 4'd7, 32'h7770);
    chk_state("R7", 32'h7770, 4'd7, 1'b0);
    pop();
    chk("R7", "count forced to one", {31'd0, empty_o}, 32'd1);
    chk("R7", "index after pop", {28'd0, top_idx_o}, 32'd6);
  endtask

  task automatic t_priority();
    do_reset();
    cycle(1'b1, 32'h900, 1'b0, 1'b1, 4'd5, 32'h5550);
    chk_state("R8", 32'h5550, 4'd5, 1'b0);
    pop();
    chk("R8", "push left no entry", {31'd0, empty_o}, 32'd1);
    chk("R8", "slot 6 untouched", {28'd0, top_idx_o}, 32'd4);
    push(32'h40);
    push(32'h60);
    chk_state("R8", 32'h64, 4'd6, 1'b0);
    do_reset();
    push(32'h10);
    cycle(1'b1, 32'h20, 1'b1, 1'b0, 4'd0, 32'd0);
    chk_state("R9", 32'h24, 4'd1, 1'b0);
    pop();
    chk_state("R9", 32'h14, 4'd0, 1'b0);
    pop();
    chk("R9", "empty after two pops", {31'd0, empty_o}, 32'd1);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lifo();
    t_empty_pop();
    t_overflow();
    t_repair();
    t_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule